// File: doc/BRIEF.md
# Presettable Cascadable Down Counter

The block is a binary down counter with a parallel load. Every control input is active-low, and so is the terminal-count output. While counting is enabled, the count drops by one on each rising clock edge. After zero it wraps to the all-ones value, so a full cycle lasts 2^W clocks.

The count can be replaced by a load word in two ways. The synchronous load takes effect at the next clock edge. The asynchronous load takes effect at once, without a clock. A reset input drives the count asynchronously to all ones, not to zero.

The terminal-count output is low only while the count is zero and counting is enabled. It is decoded combinationally. Because of this, a stage can drive the count-enable of the next stage directly, and several stages can be chained in either a synchronous or a ripple arrangement.

Internally, a decoder resolves the four controls into one named operation on each cycle:
- OP_RESET: the reset input is low.
- OP_ALOAD: the asynchronous load is active.
- OP_SLOAD: the synchronous load is active.
- OP_COUNT: counting is enabled.
- OP_HOLD: none of the above applies.

The decoder gives priority from top to bottom in the order listed. Whatever the starting state, the counter moves from state to state as follows:
- `count -> count-1` under OP_COUNT, with `0 -> all-ones` as the wrap.
- `count -> load_val` under OP_SLOAD or OP_ALOAD.
- `count -> all-ones` under OP_RESET.
- `count -> count` under OP_HOLD.

Top module: `dncnt_jam`

## Requirements
- R1: While `rst_max_n` is low, `count` is all ones (255 for W=8). This takes effect at once, without waiting for a clock, and it overrides every other input.
- R2: When `rst_max_n`, `aload_n` and `sload_n` are high and `cnt_en_n` is low, each rising clock edge lowers `count` by exactly one.
- R3: When `cnt_en_n` is high and no load or reset is active, `count` does not change across clock edges.
- R4: `zero_n` is 0 exactly when `count` is 0 and `cnt_en_n` is 0; otherwise it is 1. It follows its inputs combinationally, without waiting for a clock edge.
- R5: When `sload_n` is low, with `aload_n` and `rst_max_n` high, the next rising edge loads `load_val` into `count`, whatever the value of `cnt_en_n`.
- R6: When `aload_n` is low, with `rst_max_n` high, `count` takes `load_val` at once, without a clock edge, whatever the values of `sload_n` and `cnt_en_n`.
- R7: Priority runs from highest to lowest: `rst_max_n`, then `aload_n`, then `sload_n`, then `cnt_en_n`.
- R8: A count at 0 that is enabled moves to all ones on the next edge. A free-running counter therefore shows one `zero_n` low pulse every 256 clocks.
- R9: While `cnt_en_n` is high, `zero_n` is high, even when `count` is 0. A stage whose `cnt_en_n` is driven by an upstream `zero_n` is therefore held until the upstream stage reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_max_n | input | 1 | Asynchronous reset to all ones, active-low |
| aload_n | input | 1 | Asynchronous load of `load_val`, active-low |
| sload_n | input | 1 | Synchronous load of `load_val`, active-low |
| cnt_en_n | input | 1 | Count enable, active-low |
| load_val | input | W | Parallel load word |
| count | output | W | Current count |
| zero_n | output | 1 | Terminal count, active-low |

## Verification
A wrong count shows at `count` on the first edge after the fault. It also shows within at most 2^W edges as a `zero_n` pulse that is misplaced or missing. A wrong precedence decode shows as a wrong loaded value straight after the edge, or straight after the asynchronous event, in which the controls conflict. A terminal-count decode that is registered, or that ignores the enable, shows within the same cycle: `zero_n` is wrong when `cnt_en_n` toggles with no clock edge in between.

// File: rtl/dncnt_pkg.sv
package dncnt_pkg;
    typedef enum logic [2:0] {
        OP_RESET = 3'd0,
        OP_ALOAD = 3'd1,
        OP_SLOAD = 3'd2,
        OP_COUNT = 3'd3,
        OP_HOLD  = 3'd4
    } op_e;
endpackage

// File: rtl/dncnt_ctl.sv
module dncnt_ctl
    import dncnt_pkg::*;
(
    input  logic rst_max_n,
    input  logic aload_n,
    input  logic sload_n,
    input  logic cnt_en_n,
    output op_e  op
);
    // Fixed priority: reset, then async load, then sync load, then enable (R7)
    always_comb begin
        if (!rst_max_n)     op = OP_RESET;
        else if (!aload_n)  op = OP_ALOAD;
        else if (!sload_n)  op = OP_SLOAD;
        else if (!cnt_en_n) op = OP_COUNT;
        else                op = OP_HOLD;
    end
endmodule

// File: rtl/dncnt_reg.sv
module dncnt_reg
    import dncnt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_max_n,
    input  logic         aload_n,
    input  op_e          op,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE      = W'(1);

    logic [W-1:0] nxt;

    always_comb begin
        unique case (op)
            OP_RESET: nxt = ALL_ONES;
            OP_ALOAD: nxt = load_val;
            OP_SLOAD: nxt = load_val;
            OP_COUNT: nxt = count - ONE;   // wraps 0 -> all ones (R8)
            OP_HOLD:  nxt = count;
            default:  nxt = count;
        endcase
    end

    // Reset and asynchronous load act as asynchronous set/load terms (R1, R6)
    always_ff @(posedge clk or negedge rst_max_n or negedge aload_n) begin
        if (!rst_max_n)    count <= ALL_ONES;
        else if (!aload_n) count <= load_val;
        else               count <= nxt;
    end
endmodule

// File: rtl/dncnt_tc.sv
module dncnt_tc #(
    parameter int W = 8
) (
    input  logic [W-1:0] count,
    input  logic         cnt_en_n,
    output logic         zero_n
);
    always_comb zero_n = ~((count == '0) & ~cnt_en_n);
endmodule

// File: rtl/dncnt_jam.sv
module dncnt_jam
    import dncnt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_max_n,
    input  logic         aload_n,
    input  logic         sload_n,
    input  logic         cnt_en_n,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         zero_n
);
    op_e op;

    dncnt_ctl u_ctl (
        .rst_max_n (rst_max_n),
        .aload_n   (aload_n),
        .sload_n   (sload_n),
        .cnt_en_n  (cnt_en_n),
        .op        (op)
    );

    dncnt_reg #(.W(W)) u_reg (
        .clk       (clk),
        .rst_max_n (rst_max_n),
        .aload_n   (aload_n),
        .op        (op),
        .load_val  (load_val),
        .count     (count)
    );

    dncnt_tc #(.W(W)) u_tc (
        .count     (count),
        .cnt_en_n  (cnt_en_n),
        .zero_n    (zero_n)
    );
endmodule

// File: rtl/dncnt_jam_chk.sv
module dncnt_jam_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_max_n,
    input logic         aload_n,
    input logic         sload_n,
    input logic         cnt_en_n,
    input logic [W-1:0] load_val,
    input logic [W-1:0] count,
    input logic         zero_n
);
    p_reset_max_r1: assert property (@(posedge clk)
        !rst_max_n |-> count == {W{1'b1}});

    p_decrement_r2: assert property (@(posedge clk) disable iff (!rst_max_n)
        (rst_max_n && aload_n && sload_n && !cnt_en_n)
        |=> (!aload_n || count == W'($past(count) - W'(1))));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_max_n)
        (rst_max_n && aload_n && sload_n && cnt_en_n)
        |=> (!aload_n || count == $past(count)));

    p_tc_low_r4: assert property (@(posedge clk) disable iff (!rst_max_n)
        (count == '0 && !cnt_en_n) |-> !zero_n);

    p_tc_high_r9: assert property (@(posedge clk) disable iff (!rst_max_n)
        (cnt_en_n || count != '0) |-> zero_n);

    p_sload_r5: assert property (@(posedge clk) disable iff (!rst_max_n)
        (rst_max_n && aload_n && !sload_n)
        |=> (!aload_n || count == $past(load_val)));

    p_aload_r6: assert property (@(posedge clk) disable iff (!rst_max_n)
        (!aload_n && $stable(load_val)) |-> count == load_val);

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_max_n)
        (rst_max_n && aload_n && sload_n && !cnt_en_n && count == '0)
        |=> (!aload_n || count == {W{1'b1}}));
endmodule

bind dncnt_jam dncnt_jam_chk #(.W(W)) u_chk (.*);

// File: tb/dncnt_jam_tb_top.sv
`timescale 1ns/1ps
module dncnt_jam_tb_top;
    localparam int W = 8;
    localparam int NV = 13;
    // {rst_max_n, aload_n, sload_n, cnt_en_n, load_val, exp_count, exp_zero_n}
    localparam logic [20:0] VEC [NV] = '{
        {4'b0111, 8'h00, 8'hFF, 1'b1},  // R1 reset
        {4'b1111, 8'h00, 8'hFF, 1'b1},  // R3 hold
        {4'b1101, 8'h03, 8'h03, 1'b1},  // R5 sync load with enable off
        {4'b1110, 8'h00, 8'h02, 1'b1},  // R2
        {4'b1110, 8'h00, 8'h01, 1'b1},  // R2
        {4'b1110, 8'h00, 8'h00, 1'b0},  // R4 terminal count
        {4'b1110, 8'h00, 8'hFF, 1'b1},  // R8 wrap
        {4'b1111, 8'h00, 8'hFF, 1'b1},  // R3 hold
        {4'b1000, 8'h05, 8'h05, 1'b1},  // R6/R7 async load beats sync/enable
        {4'b1110, 8'h00, 8'h04, 1'b1},  // R2
        {4'b1101, 8'h00, 8'h00, 1'b1},  // R9 zero but disabled
        {4'b0000, 8'h33, 8'hFF, 1'b1},  // R7 reset beats all
        {4'b1110, 8'h00, 8'hFE, 1'b1}   // R2 after reset
    };

    logic clk = 1'b0;
    logic rst_max_n = 1'b1, aload_n = 1'b1, sload_n = 1'b1, cnt_en_n = 1'b1;
    logic [W-1:0] load_val = '0;
    logic [W-1:0] count;
    logic zero_n;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dncnt_jam #(.W(W)) dut_i (
        .clk(clk), .rst_max_n(rst_max_n), .aload_n(aload_n), .sload_n(sload_n),
        .cnt_en_n(cnt_en_n), .load_val(load_val), .count(count), .zero_n(zero_n)
    );

    task automatic chk(input string req, input logic [W-1:0] exp_c, input logic exp_z);
        n_chk++;
        if (count !== exp_c || zero_n !== exp_z) begin
            n_fail++;
            $display("FAIL %s: count=%h zero_n=%b expected count=%h zero_n=%b",
                     req, count, zero_n, exp_c, exp_z);
        end
    endtask

    initial begin
        #1 rst_max_n = 1'b0;
        for (int i = 0; i < NV; i++) begin
            {rst_max_n, aload_n, sload_n, cnt_en_n, load_val} = VEC[i][20:9];
            @(negedge clk);
            chk($sformatf("vector %0d (R1-R9 table)", i), VEC[i][8:1], VEC[i][0]);
        end
        // R6: async load visible before any clock edge
        aload_n = 1'b0; load_val = 8'hA5; #1;
        chk("R6 async load immediate", 8'hA5, 1'b1);
        @(negedge clk); aload_n = 1'b1; cnt_en_n = 1'b1;
        // R1: async reset visible before any clock edge
        rst_max_n = 1'b0; #1;
        chk("R1 async reset immediate", 8'hFF, 1'b1);
        rst_max_n = 1'b1;
        // R4/R9: combinational terminal count follows enable with no clock
        sload_n = 1'b0; load_val = 8'h00; @(negedge clk); sload_n = 1'b1;
        chk("R9 zero count disabled", 8'h00, 1'b1);
        cnt_en_n = 1'b0; #1;
        chk("R4 combinational tc", 8'h00, 1'b0);
        cnt_en_n = 1'b1; #1;
        chk("R9 enable release", 8'h00, 1'b1);
        // R8: 256-clock cycle with a single terminal pulse
        begin
            int lows = 0;
            cnt_en_n = 1'b0;
            for (int k = 0; k < 256; k++) begin
                @(negedge clk);
                if (!zero_n) lows++;
            end
            n_chk++;
            if (lows != 1 || count !== 8'h00) begin
                n_fail++;
                $display("FAIL R8: pulses=%0d count=%h expected pulses=1 count=00", lows, count);
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule